// File: doc/BRIEF.md
# Vector Phase Reconstruction Unit

This block is the last stage of a scaling-free vectoring pipeline that measures the magnitude and phase of a two-component vector. Before that pipeline runs, every input vector is first rotated into the first quadrant and then folded into the sector [0, π/8]. The pipeline therefore returns only a partial angle. It also returns two tags: one names the sector where the vector started inside the first quadrant, and one names the quadrant where it started.

The unit turns the partial angle back into a full-circle phase. It does this with a single signed addition per sample, using a combined constant and an optional negation of the partial angle. The tags choose both. Any result that falls outside [0, 2π) is brought back into that range. The magnitude is carried through unchanged, and it reaches the outputs on the same clock edge as its phase.

Top module: `phase_rebuild`

## Requirements
- R1: While reset is active, out_valid, out_phase and out_mag are all zero.
- R2: Sector tag 0 (the lowest sector) keeps the partial angle as it is: the phase is φ plus the quadrant offset.
- R3: Sector tag 1 reflects the partial angle about π/4: the phase is π/4 − φ plus the quadrant offset.
- R4: Sector tag 2 shifts the partial angle by π/4: the phase is π/4 + φ plus the quadrant offset.
- R5: Sector tag 3 reflects the partial angle about π/2: the phase is π/2 − φ plus the quadrant offset.
- R6: Quadrant tag q adds q·π/2. The partial angle and the phase are both unsigned codes with LSB 2^-13 rad. The constants are rounded to the nearest code: π/4 = 6434, π/2 = 12868, π = 25736, 3π/2 = 38604.
- R7: out_phase always lies in [0, 51472), where 51472 is the code for 2π. A sum at or above 51472 has 51472 subtracted from it, and a negative sum has 51472 added to it.
- R8: The latency is one clock. A sample presented with in_valid high at a rising edge appears on out_valid, out_phase and out_mag right after that edge.
- R9: out_mag equals in_mag of the same sample, bit for bit.
- R10: If in_valid is low at an edge, out_valid goes low after that edge, and out_phase and out_mag keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| in_valid | input | 1 | Sample strobe |
| in_quad | input | 2 | Starting quadrant, 0 to 3 |
| in_domain | input | 2 | Sector tag within the first quadrant, 0 to 3 |
| in_angle | input | 13 | Folded partial angle φ, LSB 2^-13 rad |
| in_mag | input | 16 | Vector magnitude from the pipeline |
| out_valid | output | 1 | Result strobe |
| out_phase | output | 16 | Full-circle phase, LSB 2^-13 rad |
| out_mag | output | 16 | Magnitude, aligned with out_phase |

## Verification
A wrong constant or a wrong negation choice for one tag pair shows up as a miscompare of out_phase on the edge after any sample that carries that pair. Random tags reach every pair many times within a few hundred samples. A fault in the wrap logic shows up only at the extremes, so it is provoked directly: sector 3 in quadrant 3 with φ = 0 gives exactly 2π, and sector 1 with the largest φ goes negative. A hold register that loads when it should not is caught on the first invalid cycle, because the previous result then changes.

// File: rtl/phase_rebuild_pkg.sv
package phase_rebuild_pkg;

  typedef enum logic [1:0] {
    SECT_LOW  = 2'd0,
    SECT_MIRQ = 2'd1,
    SECT_UPQ  = 2'd2,
    SECT_TOP  = 2'd3
  } sector_e;

  localparam real PI_R = 3.14159265358979323846;

  // Angle in radians -> unsigned code with LSB 2^-frac, rounded to nearest.
  function automatic int rad_code(input real rad, input int frac);
    return int'(rad * (2.0 ** frac));
  endfunction

endpackage

// File: rtl/phase_rst_sync.sv
module phase_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/phase_offset_sel.sv
module phase_offset_sel
  import phase_rebuild_pkg::*;
#(
  parameter int PH_W = 16,
  parameter int FRAC = 13
) (
  input  sector_e          sector,
  input  logic [1:0]       quad,
  output logic [PH_W-1:0]  base,
  output logic             negate
);
  localparam logic [PH_W-1:0] QTR_PI  = PH_W'(rad_code(PI_R / 4.0, FRAC));
  localparam logic [PH_W-1:0] HALF_PI = PH_W'(rad_code(PI_R / 2.0, FRAC));

  logic [PH_W-1:0] quad_tab [4];
  logic [PH_W-1:0] fold_base;

  for (genvar g = 0; g < 4; g++) begin : g_quad
    assign quad_tab[g] = PH_W'(rad_code(PI_R / 2.0 * real'(g), FRAC));
  end

  always_comb begin
    fold_base = '0;
    negate    = 1'b0;
    unique case (sector)
      SECT_LOW:  begin fold_base = '0;      negate = 1'b0; end
      SECT_MIRQ: begin fold_base = QTR_PI;  negate = 1'b1; end
      SECT_UPQ:  begin fold_base = QTR_PI;  negate = 1'b0; end
      SECT_TOP:  begin fold_base = HALF_PI; negate = 1'b1; end
      default:   begin fold_base = '0;      negate = 1'b0; end
    endcase
  end

  assign base = fold_base + quad_tab[quad];
endmodule

// File: rtl/phase_wrap_add.sv
module phase_wrap_add
  import phase_rebuild_pkg::*;
#(
  parameter int PH_W  = 16,
  parameter int ANG_W = 13,
  parameter int FRAC  = 13
) (
  input  logic [PH_W-1:0]  base,
  input  logic             negate,
  input  logic [ANG_W-1:0] angle,
  output logic [PH_W-1:0]  phase
);
  localparam int SUM_W  = PH_W + 2;
  localparam int TWO_PI = rad_code(2.0 * PI_R, FRAC);
  localparam logic signed [SUM_W-1:0] TWO_PI_S = SUM_W'(TWO_PI);

  logic signed [SUM_W-1:0] addend;
  logic signed [SUM_W-1:0] raw;
  logic signed [SUM_W-1:0] wrapped;

  always_comb begin
    addend = $signed(SUM_W'(angle));
    if (negate) addend = -addend;
    raw = $signed(SUM_W'(base)) + addend;
    if (raw < 0)              wrapped = raw + TWO_PI_S;
    else if (raw >= TWO_PI_S) wrapped = raw - TWO_PI_S;
    else                      wrapped = raw;
  end

  assign phase = wrapped[PH_W-1:0];
endmodule

// File: rtl/phase_rebuild.sv
module phase_rebuild
  import phase_rebuild_pkg::*;
#(
  parameter int PH_W  = 16,
  parameter int ANG_W = 13,
  parameter int MAG_W = 16,
  parameter int FRAC  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_quad,
  input  logic [1:0]       in_domain,
  input  logic [ANG_W-1:0] in_angle,
  input  logic [MAG_W-1:0] in_mag,
  output logic             out_valid,
  output logic [PH_W-1:0]  out_phase,
  output logic [MAG_W-1:0] out_mag
);
  localparam int TWO_PI = rad_code(2.0 * PI_R, FRAC);

  logic             rst_sync_n;
  logic [PH_W-1:0]  base;
  logic             negate;
  logic [PH_W-1:0]  phase_sum;
  sector_e          sector;

  logic             valid_d, valid_q;
  logic [PH_W-1:0]  phase_d, phase_q;
  logic [MAG_W-1:0] mag_d, mag_q;

  phase_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign sector = sector_e'(in_domain);

  phase_offset_sel #(.PH_W(PH_W), .FRAC(FRAC)) u_sel (
    .sector (sector),
    .quad   (in_quad),
    .base   (base),
    .negate (negate)
  );

  phase_wrap_add #(.PH_W(PH_W), .ANG_W(ANG_W), .FRAC(FRAC)) u_add (
    .base   (base),
    .negate (negate),
    .angle  (in_angle),
    .phase  (phase_sum)
  );

  always_comb begin
    valid_d = in_valid;
    phase_d = phase_q;
    mag_d   = mag_q;
    if (in_valid) begin
      phase_d = phase_sum;
      mag_d   = in_mag;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      phase_q <= '0;
      mag_q   <= '0;
    end else begin
      valid_q <= valid_d;
      phase_q <= phase_d;
      mag_q   <= mag_d;
    end
  end

  assign out_valid = valid_q;
  assign out_phase = phase_q;
  assign out_mag   = mag_q;

  // R8
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> (!out_valid && $stable(out_phase) && $stable(out_mag)));

  // R9
  mag_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_mag == $past(in_mag));

  // R7
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> out_phase < PH_W'(TWO_PI));

  // R2
  sector_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_domain == 2'd0 && in_quad == 2'd0)
      |=> out_phase == PH_W'($past(in_angle)));
endmodule

// File: tb/phase_rebuild_test.sv
`timescale 1ns/1ps
module phase_rebuild_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_quad;
  logic [1:0]  in_domain;
  logic [12:0] in_angle;
  logic [15:0] in_mag;
  logic        out_valid;
  logic [15:0] out_phase;
  logic [15:0] out_mag;

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] exp_phase = '0;
  logic [15:0] exp_mag   = '0;

  always #2.5 clk = ~clk;

  phase_rebuild uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_quad(in_quad),
    .in_domain(in_domain), .in_angle(in_angle), .in_mag(in_mag),
    .out_valid(out_valid), .out_phase(out_phase), .out_mag(out_mag)
  );

  function automatic int code_of(input real r);
    return $rtoi(r * 8192.0 + 0.5);
  endfunction

  function automatic int ref_phase(input int q, input int d, input int a);
    real pi = 3.14159265358979323846;
    int two = code_of(2.0 * pi);
    int s;
    case (d)
      0: s = a;
      1: s = code_of(pi / 4.0) - a;
      2: s = code_of(pi / 4.0) + a;
      default: s = code_of(pi / 2.0) - a;
    endcase
    case (q)
      0: s = s;
      1: s = s + code_of(pi / 2.0);
      2: s = s + code_of(pi);
      default: s = s + code_of(3.0 * pi / 2.0);
    endcase
    if (s < 0) s = s + two;
    else if (s >= two) s = s - two;
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string dom_req(input int d);
    case (d)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // Drive one cycle at a negedge, check at the following negedge.
  task automatic step(input logic v, input int q, input int d, input int a, input int m);
    in_valid  = v;
    in_quad   = 2'(q);
    in_domain = 2'(d);
    in_angle  = 13'(a);
    in_mag    = 16'(m);
    if (v) begin
      exp_phase = 16'(ref_phase(q, d, a));
      exp_mag   = 16'(m);
    end
    @(negedge clk);
    check("R8 valid", int'(out_valid), int'(v));
    check(v ? dom_req(d) : "R10 hold", int'(out_phase), int'(exp_phase));
    check(v ? "R9 mag" : "R10 mag hold", int'(out_mag), int'(exp_mag));
  endtask

  initial begin
    #1000000;
    n_fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    rst_n = 1'b0; in_valid = 1'b0; in_quad = '0; in_domain = '0;
    in_angle = '0; in_mag = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", int'(out_valid), 0);
    check("R1 phase", int'(out_phase), 0);
    check("R1 mag",   int'(out_mag), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 quadrant offsets with phi = 0 in the lowest sector
    step(1'b1, 0, 0, 0, 11);
    step(1'b1, 1, 0, 0, 12); check("R6 half-pi", int'(out_phase), 12868);
    step(1'b1, 2, 0, 0, 13); check("R6 pi",      int'(out_phase), 25736);
    step(1'b1, 3, 0, 0, 14); check("R6 3pi/2",   int'(out_phase), 38604);
    step(1'b1, 0, 2, 0, 15); check("R6 pi/4",    int'(out_phase), 6434);
    // R7 wrap corners
    step(1'b1, 3, 3, 0, 16);    check("R7 exact 2pi", int'(out_phase), 0);
    step(1'b1, 0, 1, 8191, 17); check("R7 negative",  int'(out_phase), 49715);
    step(1'b1, 3, 2, 8191, 18); check("R7 over",      int'(out_phase), 53229 - 51472);
    step(1'b1, 0, 3, 3217, 19); check("R5 mid",       int'(out_phase), 9651);
    // R10 idle cycles with junk on the inputs
    step(1'b0, 2, 1, 4000, 16'hbeef);
    step(1'b0, 1, 3, 77, 16'h1234);
    step(1'b1, 2, 1, 1000, 16'hffff);

    for (int i = 0; i < 600; i++) begin
      step(($urandom % 4) != 0, $urandom % 4, $urandom % 4,
           $urandom % 8192, $urandom % 65536);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule